// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block serialises characters onto a single output line using a configurable asynchronous frame. A character written into a one-entry holding buffer is moved into an internal shift register when the shifter is free. It then goes out as one low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Timing comes from an external enable pulse at sixteen times the bit rate. Each bit is held for sixteen of those pulses.

Because of the holding buffer, software can write the next character while the current one is still shifting. The next character starts straight after the last stop bit, with no idle gap. Two flags report status. `empty_o` shows whether the holding buffer can take a character. `busy_o` shows whether a frame is on the line. A break control holds the line low and suppresses frames for as long as it stays set.

The controller has six states. IDLE holds the line high. START, DATA, PAR and STOP each drive one part of the frame. BRK holds the line low. Its transitions are as follows:
- LOAD: IDLE to START, on a tick while the buffer holds a character.
- START_END: START to DATA.
- DATA_END: DATA to PAR, or DATA to STOP when parity is off. It is taken after the last data bit.
- PAR_END: PAR to STOP.
- CHAIN: STOP to START. It is taken at the end of the final stop bit when the buffer is full.
- FINISH: STOP to IDLE. It is taken at the same point when the buffer is empty.
- BREAK: from any state to BRK, while the break control is high.
- RELEASE: BRK to IDLE.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame or break is active, `txd_o` is 1, `busy_o` is 0, and `empty_o` is 1 until a character is written.
- R2: A frame consists of the following bits, in this order:
  - one start bit at 0;
  - the data bits, least significant first;
  - the optional parity bit;
  - the stop bits at 1.

  `len_sel_i` selects the data length: 0 selects 7 bits, 2 selects 9 bits, and 1 or 3 selects 8 bits. Unused upper bits of `wr_data_i` are not sent. `stop2_i` = 1 selects two stop bits and 0 selects one.
- R3: `par_sel_i` selects the parity bit. 0 sends no parity bit. 1 is odd, so the data bits plus parity hold an odd number of ones. 2 is even. 3 is mark (always 1) and 4 is space (always 0). Codes 5 to 7 send no parity bit.
- R4: Every bit of a frame lasts exactly 16 `tick_i` pulses.
- R5: `empty_o` goes to 0 in the cycle after a write (`wr_i` = 1). It returns to 1 in the cycle after the buffer is copied into the shift register.
- R6: When no frame is in progress, a buffered character does not start before a tick. The start bit begins in the cycle after the first `tick_i` following the write.
- R7: A character that is buffered during a frame starts its start bit right after the final stop bit of the current frame, with no idle bit time in between.
- R8: `busy_o` is 1 from the start bit through the last stop bit. It drops after the last stop bit only if the buffer is empty, and it stays 1 across chained frames.
- R9: While `break_i` is 1, `txd_o` is 0 from the next cycle on, any frame in progress is abandoned, no new frame starts and a buffered character is kept. After `break_i` returns to 0 the line goes high, and a kept character is sent on a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| break_i | input | 1 | Hold the line low and suppress frames |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 9 | Character to write |
| len_sel_i | input | 2 | Data length code |
| stop2_i | input | 1 | Two stop bits when 1 |
| par_sel_i | input | 3 | Parity mode code |
| txd_o | output | 1 | Serial line, idles high |
| empty_o | output | 1 | Holding buffer empty |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench targets the following corner cases:
- **Data-length and parity codes.** Every code is sent with data whose upper bits would corrupt a 7-bit frame if they leaked through. Code 3 is among them. A mis-decoded length shifts every later bit, and a wrong parity polarity flips one bit.
- **Start timing.** The bench holds back ticks after a write to show that nothing starts early. A design that ignored the tick would begin at once.
- **Bit length.** A single data bit is timed to exactly 32 cycles at two cycles per tick. An off-by-one tick counter gives 30 or 34 cycles.
- **Chained frames.** The second character must begin exactly one bit time after the first frame's stop bit, with the busy flag unbroken. A design that went through IDLE would insert a gap or drop busy.
- **Break.** Break is applied both idle and mid-frame. A design that finished the frame, lost the buffered character or released the line late is caught there.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int MAX_DATA_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRK   = 3'd5
    } tx_state_e;

    typedef enum logic [2:0] {
        PM_NONE  = 3'd0,
        PM_ODD   = 3'd1,
        PM_EVEN  = 3'd2,
        PM_MARK  = 3'd3,
        PM_SPACE = 3'd4
    } par_mode_e;

    function automatic logic [3:0] len_to_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    return 4'd7;
            2'd2:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_o  <= '0;
            empty_o <= 1'b1;
        end else if (wr_i) begin
            data_o  <= wr_data_i;
            empty_o <= 1'b0;
        end else if (take_i) begin
            empty_o <= 1'b1;
        end
    end

    // R5: a write always leaves the buffer full
    p_wr_clears_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> !empty_o);

    // R5: a copy into the shifter with no write frees the buffer
    p_take_sets_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !wr_i) |=> empty_o);

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [3:0]        nbits_i,
    input  logic [2:0]        mode_i,
    output logic              en_o,
    output logic              bit_o
);
    import sertx_pkg::*;

    logic acc;

    always_comb begin
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < nbits_i) acc = acc ^ data_i[i];
        end
    end

    always_comb begin
        en_o  = 1'b1;
        bit_o = 1'b0;
        unique case (mode_i)
            PM_ODD:   bit_o = ~acc;
            PM_EVEN:  bit_o = acc;
            PM_MARK:  bit_o = 1'b1;
            PM_SPACE: bit_o = 1'b0;
            default:  en_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DATA_W        = 9,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              break_i,
    input  logic              have_data_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        len_sel_i,
    input  logic              stop2_i,
    input  logic              par_en_i,
    input  logic              par_bit_i,
    output logic              take_o,
    output logic              txd_o,
    output logic              busy_o
);
    import sertx_pkg::*;

    localparam int CW  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BCW = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BCW-1:0]    bit_q, bit_d;
    logic [BCW-1:0]    nb_q, nb_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              st2_q, st2_d;
    logic              pe_q, pe_d;
    logic              pb_q, pb_d;
    logic              bit_end;

    assign bit_end = tick_i && (cnt_q == CW'(TICKS_PER_BIT - 1));

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        nb_d    = nb_q;
        sh_d    = sh_q;
        st2_d   = st2_q;
        pe_d    = pe_q;
        pb_d    = pb_q;
        take_o  = 1'b0;
        if (break_i) begin
            state_d = ST_BRK;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (tick_i && have_data_i) take_o = 1'b1;
                ST_START: if (bit_end) begin
                    state_d = ST_DATA;
                    bit_d   = '0;
                end
                ST_DATA:  if (bit_end) begin
                    sh_d = sh_q >> 1;
                    if (bit_q == nb_q - 1'b1) begin
                        bit_d   = '0;
                        state_d = pe_q ? ST_PAR : ST_STOP;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
                ST_PAR:   if (bit_end) begin
                    state_d = ST_STOP;
                    bit_d   = '0;
                end
                ST_STOP:  if (bit_end) begin
                    if (st2_q && bit_q == '0) bit_d = 1'b1;
                    else if (have_data_i)     take_o = 1'b1;
                    else                      state_d = ST_IDLE;
                end
                ST_BRK:   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
        if (take_o) begin
            state_d = ST_START;
            bit_d   = '0;
            sh_d    = data_i;
            nb_d    = BCW'(len_to_bits(len_sel_i));
            st2_d   = stop2_i;
            pe_d    = par_en_i;
            pb_d    = par_bit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            nb_q    <= BCW'(8);
            sh_q    <= '0;
            st2_q   <= 1'b0;
            pe_q    <= 1'b0;
            pb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            nb_q    <= nb_d;
            sh_q    <= sh_d;
            st2_q   <= st2_d;
            pe_q    <= pe_d;
            pb_q    <= pb_d;
            if (take_o || state_d == ST_IDLE || state_d == ST_BRK) cnt_q <= '0;
            else if (bit_end)                                      cnt_q <= '0;
            else if (tick_i)                                       cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        txd_o  = 1'b1;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_START: txd_o  = 1'b0;
            ST_DATA:  txd_o  = sh_q[0];
            ST_PAR:   txd_o  = pb_q;
            ST_STOP:  txd_o  = 1'b1;
            ST_BRK:   begin txd_o = 1'b0; busy_o = 1'b0; end
            default:  busy_o = 1'b0;
        endcase
    end

    // R2: every frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !txd_o);

    // R4: within a frame the line only moves on a tick
    p_bit_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i && !break_i) |=> $stable(txd_o));

    // R6: idle with data and a tick begins a frame
    p_idle_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && txd_o && tick_i && have_data_i && !break_i) |=> busy_o);

    // R9: break pulls the line low on the next cycle
    p_break_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_i |=> (!txd_o && !busy_o));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W        = sertx_pkg::MAX_DATA_W,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              break_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        len_sel_i,
    input  logic              stop2_i,
    input  logic [2:0]        par_sel_i,
    output logic              txd_o,
    output logic              empty_o,
    output logic              busy_o
);
    import sertx_pkg::*;

    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              par_en;
    logic              par_bit;

    sertx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .take_i    (take),
        .data_o    (hold_data),
        .empty_o   (empty_o)
    );

    sertx_parity #(.DATA_W(DATA_W)) u_par (
        .data_i  (hold_data),
        .nbits_i (len_to_bits(len_sel_i)),
        .mode_i  (par_sel_i),
        .en_o    (par_en),
        .bit_o   (par_bit)
    );

    sertx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .break_i     (break_i),
        .have_data_i (!empty_o),
        .data_i      (hold_data),
        .len_sel_i   (len_sel_i),
        .stop2_i     (stop2_i),
        .par_en_i    (par_en),
        .par_bit_i   (par_bit),
        .take_o      (take),
        .txd_o       (txd_o),
        .busy_o      (busy_o)
    );

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk = 1'b0;
    logic       wr = 1'b0;
    logic [8:0] wdata = '0;
    logic [1:0] len_sel = 2'd1;
    logic       stop2 = 1'b0;
    logic [2:0] par_sel = 3'd0;
    logic       auto_en = 1'b0;
    logic       tick_ph = 1'b0;
    logic       man_tick = 1'b0;
    logic       tick;
    logic       txd, empty, busy;

    int nchecks = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!auto_en) tick_ph <= 1'b0;
        else          tick_ph <= ~tick_ph;
    end
    assign tick = (auto_en & tick_ph) | man_tick;

    sertx_top dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .break_i   (brk),
        .wr_i      (wr),
        .wr_data_i (wdata),
        .len_sel_i (len_sel),
        .stop2_i   (stop2),
        .par_sel_i (par_sel),
        .txd_o     (txd),
        .empty_o   (empty),
        .busy_o    (busy)
    );

    // fields: len[15:14] stop2[13] par_sel[12:10] expected_parity[9] data[8:0]
    localparam logic [15:0] VEC [8] = '{
        {2'd1, 1'b0, 3'd0, 1'b0, 9'h055},
        {2'd0, 1'b1, 3'd1, 1'b0, 9'h00B},
        {2'd2, 1'b0, 3'd2, 1'b1, 9'h1FF},
        {2'd1, 1'b1, 3'd3, 1'b1, 9'h0A3},
        {2'd1, 1'b0, 3'd4, 1'b0, 9'h0FF},
        {2'd0, 1'b0, 3'd2, 1'b1, 9'h181},
        {2'd1, 1'b0, 3'd1, 1'b1, 9'h000},
        {2'd3, 1'b1, 3'd2, 1'b0, 9'h1F0}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] v, output logic [15:0] fr, output int n);
        int nb;
        nb = (v[15:14] == 2'd0) ? 7 : (v[15:14] == 2'd2) ? 9 : 8;
        fr = '0;
        n  = 1;
        for (int i = 0; i < nb; i++) begin fr[n] = v[i]; n++; end
        if (v[12:10] >= 3'd1 && v[12:10] <= 3'd4) begin fr[n] = v[9]; n++; end
        fr[n] = 1'b1; n++;
        if (v[13]) begin fr[n] = 1'b1; n++; end
    endtask

    task automatic rx_frame(input bit chained, input int n, output logic [15:0] rv,
                            output bit busy_all);
        int w;
        rv = '0;
        busy_all = 1'b1;
        if (!chained) begin
            w = 0;
            while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
            repeat (16) @(negedge clk);
        end else begin
            repeat (32) @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (32) @(negedge clk);
            rv[i] = txd;
            busy_all = busy_all & busy;
        end
    endtask

    task automatic write_char(input logic [8:0] d);
        wdata = d;
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic apply_cfg(input logic [15:0] v);
        len_sel = v[15:14];
        stop2   = v[13];
        par_sel = v[12:10];
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while (busy && w < 3000) begin @(negedge clk); w++; end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchecks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [15:0] exp_fr, got_fr, fa, fb;
        int n, na, nb2, w;
        bit ball;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset empty", int'(empty), 1);
        chk("R1 reset busy", int'(busy), 0);

        // frame format table walk
        auto_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            apply_cfg(VEC[k]);
            build(VEC[k], exp_fr, n);
            write_char(VEC[k][8:0]);
            chk("R5 empty after write", int'(empty), 0);
            rx_frame(1'b0, n, got_fr, ball);
            chk($sformatf("R2 R3 frame vector %0d", k), int'(got_fr), int'(exp_fr));
            chk("R8 busy through frame", int'(ball), 1);
            chk("R5 empty after load", int'(empty), 1);
            repeat (20) @(negedge clk);
            chk("R8 busy low after frame", int'(busy), 0);
            chk("R1 line idle high", int'(txd), 1);
        end

        // R6 start waits for a tick; R4 bit length
        auto_en = 1'b0;
        repeat (4) @(negedge clk);
        apply_cfg(VEC[0]);
        write_char(9'h055);
        repeat (6) @(negedge clk);
        chk("R6 no start without tick txd", int'(txd), 1);
        chk("R6 no start without tick busy", int'(busy), 0);
        man_tick = 1'b1;
        @(negedge clk);
        man_tick = 1'b0;
        chk("R6 start after tick txd", int'(txd), 0);
        chk("R6 start after tick busy", int'(busy), 1);
        auto_en = 1'b1;
        w = 0;
        while (txd !== 1'b1 && w < 200) begin @(negedge clk); w++; end
        w = 0;
        while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
        n = 0;
        while (txd === 1'b0 && n < 200) begin @(negedge clk); n++; end
        chk("R4 bit lasts 16 ticks (32 cycles)", n, 32);
        wait_idle();

        // R7 chained frames
        apply_cfg(VEC[0]);
        build({2'd1, 1'b0, 3'd0, 1'b0, 9'h03C}, fa, na);
        build({2'd1, 1'b0, 3'd0, 1'b0, 9'h0C5}, fb, nb2);
        write_char(9'h03C);
        w = 0;
        while (empty !== 1'b1 && w < 200) begin @(negedge clk); w++; end
        write_char(9'h0C5);
        chk("R5 second write fills buffer", int'(empty), 0);
        rx_frame(1'b0, na, got_fr, ball);
        chk("R7 first chained frame", int'(got_fr), int'(fa));
        rx_frame(1'b1, nb2, got_fr, ball);
        chk("R7 second frame follows without gap", int'(got_fr), int'(fb));
        chk("R8 busy held across chained frames", int'(ball), 1);
        repeat (20) @(negedge clk);
        chk("R8 busy low after chain", int'(busy), 0);

        // R9 break while idle, buffered character kept
        brk = 1'b1;
        @(negedge clk);
        chk("R9 break pulls line low", int'(txd), 0);
        write_char(9'h0A5);
        repeat (100) @(negedge clk);
        chk("R9 line low during break", int'(txd), 0);
        chk("R9 no frame during break", int'(busy), 0);
        chk("R9 buffer kept during break", int'(empty), 0);
        build({2'd1, 1'b0, 3'd0, 1'b0, 9'h0A5}, exp_fr, n);
        brk = 1'b0;
        @(negedge clk);
        chk("R9 line released high", int'(txd), 1);
        rx_frame(1'b0, n, got_fr, ball);
        chk("R9 kept character sent after break", int'(got_fr), int'(exp_fr));
        wait_idle();

        // R9 break mid-frame abandons it
        write_char(9'h0FF);
        w = 0;
        while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
        repeat (80) @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk("R9 mid-frame break low", int'(txd), 0);
        chk("R9 mid-frame break busy", int'(busy), 0);
        repeat (40) @(negedge clk);
        brk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 line high after break", int'(txd), 1);
        repeat (600) @(negedge clk);
        chk("R9 abandoned frame not resumed", int'(busy), 0);
        chk("R1 idle line after break", int'(txd), 1);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule